// File: doc/BRIEF.md
# Deflection Controller Power-Mode Sequencer

This block is the control state machine that moves a monitor deflection controller through its power modes: power-down, standby, protection, soft-start and operating, with a soft-down path back out of operating. An external power-on-reset flag holds it in power-down. Two control bits, written through one-bit register strobes, choose the mode once the supply is up: a standby bit and a soft-start bit. A set of the soft-start bit is refused while the supply-OK flag is low.

Output-stage enables, PLL enables and a bus-acknowledge enable are decoded from the mode. The horizontal and B+ drives share one duty value. It ramps up by one step every `STEP_DIV` clocks on the way into operating mode and ramps down the same way on the way out. In operating mode an active-high unlock output follows the PLL1 lock flag with no delay. A 2-bit state code and a ramp flag report the mode.

Top module: `defl_pwr_seq`

## Requirements
- R1: While `porActive` is high the block is in power-down, with code {stateCode,rampFlag} = 000, every enable low including `busAck`, and `driveDuty` 0. On the first clock edge after `porActive` falls it enters standby, with code 010. In standby only `busAck` is high, `unlockOut` is 1, and the standby bit reads 1 and the soft-start bit reads 0.
- R2: In standby, a write of 0 to the standby bit gives protection mode (code 100) on the clock edge after the write edge. In protection, `busAck`, `supplyEn` and `vertEn` are high, the horizontal, B+ and PLL enables are low, and `unlockOut` is 1. Writing the standby bit to 1 in protection returns to standby.
- R3: A write of 1 to the soft-start bit while `supplyOk` is low is ignored, and the block stays in protection.
- R4: In protection with `supplyOk` high, a write of 1 to the soft-start bit gives soft-start (code 111) on the edge after the write edge. All seven enables are high. `driveDuty` starts at 0 and rises by one every `STEP_DIV` clocks.
- R5: Soft-start ends at full duty (all ones) and enters operating mode (code 110) exactly 255·`STEP_DIV`+1 clocks after it began, with the default 8-bit duty. `driveDuty` stays at full while operating.
- R6: In operating mode `unlockOut` equals the inverse of `pllLock`, combinationally.
- R7: In operating mode, clearing the soft-start bit gives soft-down (code 101). `driveDuty` falls by one every `STEP_DIV` clocks, and the block returns to protection 255·`STEP_DIV`+1 clocks after soft-down began, with `driveDuty` 0.
- R8: Writes to the standby bit during soft-start, operating or soft-down do not change the mode. A standby bit left at 1 takes effect once soft-down has reached protection, and the block then enters standby on the following edge.
- R9: Raising `porActive` in any mode forces power-down at once, without waiting for a clock edge. After release the block restarts in standby with the standby bit at 1 and the soft-start bit at 0.
- R10: Clearing the soft-start bit during soft-start begins soft-down from the current duty. Protection follows duty·`STEP_DIV`+1 clocks after soft-down began.
- R11: Setting the soft-start bit during soft-down does not reverse the ramp. The ramp reaches zero and enters protection, and soft-start begins on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porActive | input | 1 | Power-on reset active (supply below lower threshold), asynchronous |
| supplyOk | input | 1 | Supply above the upper threshold; gates setting the soft-start bit |
| pllLock | input | 1 | PLL1 locked |
| wrStdbyEn | input | 1 | Write strobe for the standby bit |
| wrSoftstEn | input | 1 | Write strobe for the soft-start bit |
| wrBit | input | 1 | Value carried by either write strobe |
| busAck | output | 1 | Bus acknowledge enable (low in power-down) |
| supplyEn | output | 1 | Internal supply enable |
| vertEn | output | 1 | Vertical output stage enable |
| horzEn | output | 1 | Horizontal drive enable |
| bplusEn | output | 1 | B+ drive enable |
| pll1En | output | 1 | PLL1 enable |
| pll2En | output | 1 | PLL2 enable |
| driveDuty | output | DUTY_W | Shared horizontal and B+ duty value |
| unlockOut | output | 1 | High when not locked; follows PLL1 only in operating mode |
| stateCode | output | 2 | Mode code: 00 off, 01 standby, 10 protection or soft-down, 11 soft-start or operating |
| rampFlag | output | 1 | High during soft-start and soft-down |

## Verification
The hardest state to reach from the ports is a reversal part-way through a ramp: soft-start cut short at an arbitrary duty, or a soft-start set that arrives during a soft-down. The bench walks the full start-up sequence and waits a counted number of prescaler periods, so the duty at the moment of the abort is known (10). It then clears the soft-start bit and checks both the duty the descent starts from and the exact number of clocks to protection. A second run sets the bit again during a descent from full duty and checks that the descent completes before a new soft-start begins.

// File: rtl/defl_pwr_pkg.sv
package defl_pwr_pkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_STBY,
    MODE_PROT,
    MODE_RISE,
    MODE_RUN,
    MODE_FALL
  } modeT;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic zeroDuty;
    logic restartPre;
  } rampCmdT;

endpackage

// File: rtl/defl_pwr_ramp.sv
module defl_pwr_ramp
  import defl_pwr_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int STEP_DIV = 4
) (
  input  logic              clk,
  input  logic              porActive,
  input  rampCmdT           rampCmd,
  output logic [DUTY_W-1:0] duty,
  output logic              dutyFull,
  output logic              dutyZero
);

  localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  logic tick;

  generate
    if (STEP_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] preCnt;
      logic stepping;
      assign stepping = rampCmd.stepUp | rampCmd.stepDown;
      assign tick = stepping && (preCnt == PRE_W'(STEP_DIV - 1));

      always_ff @(posedge clk or posedge porActive) begin
        if (porActive) begin
          preCnt <= '0;
        end else if (rampCmd.restartPre || !stepping || tick) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
    end
  endgenerate

  assign dutyFull = (duty == DUTY_MAX);
  assign dutyZero = (duty == '0);

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) begin
      duty <= '0;
    end else if (rampCmd.zeroDuty) begin
      duty <= '0;
    end else if (rampCmd.stepUp && tick && !dutyFull) begin
      duty <= duty + DUTY_W'(1);
    end else if (rampCmd.stepDown && tick && !dutyZero) begin
      duty <= duty - DUTY_W'(1);
    end
  end

endmodule

// File: rtl/defl_pwr_ctrl.sv
module defl_pwr_ctrl
  import defl_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       porActive,
  input  logic       supplyOk,
  input  logic       pllLock,
  input  logic       wrStdbyEn,
  input  logic       wrSoftstEn,
  input  logic       wrBit,
  input  logic       dutyFull,
  input  logic       dutyZero,
  output rampCmdT    rampCmd,
  output logic       busAck,
  output logic       supplyEn,
  output logic       vertEn,
  output logic       horzEn,
  output logic       bplusEn,
  output logic       pll1En,
  output logic       pll2En,
  output logic       unlockOut,
  output logic [1:0] stateCode,
  output logic       rampFlag
);

  modeT mode, modeNext;
  logic stdbyBit;
  logic softstBit;
  logic wrOpen;

  assign wrOpen = (mode != MODE_OFF);

  // Control bits: writes accepted only once out of power-down;
  // setting the soft-start bit additionally needs a good supply.
  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) begin
      stdbyBit  <= 1'b1;
      softstBit <= 1'b0;
    end else if (wrOpen) begin
      if (wrStdbyEn) stdbyBit <= wrBit;
      if (wrSoftstEn && (!wrBit || supplyOk)) softstBit <= wrBit;
    end
  end

  always_comb begin
    modeNext = mode;
    unique case (mode)
      MODE_OFF:  modeNext = MODE_STBY;
      MODE_STBY: if (!stdbyBit) modeNext = MODE_PROT;
      MODE_PROT: begin
        if (stdbyBit)       modeNext = MODE_STBY;
        else if (softstBit) modeNext = MODE_RISE;
      end
      MODE_RISE: begin
        if (!softstBit)     modeNext = MODE_FALL;
        else if (dutyFull)  modeNext = MODE_RUN;
      end
      MODE_RUN:  if (!softstBit) modeNext = MODE_FALL;
      MODE_FALL: if (dutyZero)   modeNext = MODE_PROT;
      default:   modeNext = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) mode <= MODE_OFF;
    else           mode <= modeNext;
  end

  // Strobes to the ramp datapath
  always_comb begin
    rampCmd.stepUp     = (mode == MODE_RISE) && (modeNext == MODE_RISE);
    rampCmd.stepDown   = (mode == MODE_FALL) && (modeNext == MODE_FALL);
    rampCmd.zeroDuty   = (mode == MODE_OFF) || (mode == MODE_STBY) || (mode == MODE_PROT);
    rampCmd.restartPre = (mode != modeNext);
  end

  // Per-mode output decode
  always_comb begin
    busAck    = 1'b0;
    supplyEn  = 1'b0;
    vertEn    = 1'b0;
    horzEn    = 1'b0;
    bplusEn   = 1'b0;
    pll1En    = 1'b0;
    pll2En    = 1'b0;
    unlockOut = 1'b1;
    stateCode = 2'b00;
    rampFlag  = 1'b0;
    unique case (mode)
      MODE_OFF: ;
      MODE_STBY: begin
        busAck    = 1'b1;
        stateCode = 2'b01;
      end
      MODE_PROT: begin
        busAck    = 1'b1;
        supplyEn  = 1'b1;
        vertEn    = 1'b1;
        stateCode = 2'b10;
      end
      MODE_RISE, MODE_RUN, MODE_FALL: begin
        busAck    = 1'b1;
        supplyEn  = 1'b1;
        vertEn    = 1'b1;
        horzEn    = 1'b1;
        bplusEn   = 1'b1;
        pll1En    = 1'b1;
        pll2En    = 1'b1;
        stateCode = (mode == MODE_FALL) ? 2'b10 : 2'b11;
        rampFlag  = (mode != MODE_RUN);
        if (mode == MODE_RUN) unlockOut = !pllLock;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/defl_pwr_seq.sv
module defl_pwr_seq
  import defl_pwr_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int STEP_DIV = 4
) (
  input  logic              clk,
  input  logic              porActive,
  input  logic              supplyOk,
  input  logic              pllLock,
  input  logic              wrStdbyEn,
  input  logic              wrSoftstEn,
  input  logic              wrBit,
  output logic              busAck,
  output logic              supplyEn,
  output logic              vertEn,
  output logic              horzEn,
  output logic              bplusEn,
  output logic              pll1En,
  output logic              pll2En,
  output logic [DUTY_W-1:0] driveDuty,
  output logic              unlockOut,
  output logic [1:0]        stateCode,
  output logic              rampFlag
);

  rampCmdT rampCmd;
  logic dutyFull;
  logic dutyZero;

  defl_pwr_ctrl ctrlInst (
    .clk        (clk),
    .porActive  (porActive),
    .supplyOk   (supplyOk),
    .pllLock    (pllLock),
    .wrStdbyEn  (wrStdbyEn),
    .wrSoftstEn (wrSoftstEn),
    .wrBit      (wrBit),
    .dutyFull   (dutyFull),
    .dutyZero   (dutyZero),
    .rampCmd    (rampCmd),
    .busAck     (busAck),
    .supplyEn   (supplyEn),
    .vertEn     (vertEn),
    .horzEn     (horzEn),
    .bplusEn    (bplusEn),
    .pll1En     (pll1En),
    .pll2En     (pll2En),
    .unlockOut  (unlockOut),
    .stateCode  (stateCode),
    .rampFlag   (rampFlag)
  );

  defl_pwr_ramp #(
    .DUTY_W   (DUTY_W),
    .STEP_DIV (STEP_DIV)
  ) rampInst (
    .clk       (clk),
    .porActive (porActive),
    .rampCmd   (rampCmd),
    .duty      (driveDuty),
    .dutyFull  (dutyFull),
    .dutyZero  (dutyZero)
  );

endmodule

// File: rtl/defl_pwr_chk.sv
module defl_pwr_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              porActive,
  input logic              supplyOk,
  input logic              pllLock,
  input logic              wrSoftstEn,
  input logic              wrBit,
  input logic              supplyEn,
  input logic              vertEn,
  input logic              horzEn,
  input logic [DUTY_W-1:0] driveDuty,
  input logic              unlockOut,
  input logic [1:0]        stateCode,
  input logic              rampFlag
);

  logic inProt, inRise, inRun, inFall;
  assign inProt = (stateCode == 2'b10) && !rampFlag;
  assign inRise = (stateCode == 2'b11) &&  rampFlag;
  assign inRun  = (stateCode == 2'b11) && !rampFlag;
  assign inFall = (stateCode == 2'b10) &&  rampFlag;

  // R2
  prot_outputs_chk: assert property (@(posedge clk) disable iff (porActive)
    inProt |-> (supplyEn && vertEn && !horzEn));

  // R3
  softst_gate_chk: assert property (@(posedge clk) disable iff (porActive)
    (inProt && wrSoftstEn && wrBit && !supplyOk) |=> ##1 !inRise);

  // R4
  rise_step_chk: assert property (@(posedge clk) disable iff (porActive)
    inRise |=> (driveDuty == $past(driveDuty) || driveDuty == $past(driveDuty) + DUTY_W'(1)));

  // R5
  run_full_chk: assert property (@(posedge clk) disable iff (porActive)
    inRun |-> (driveDuty == {DUTY_W{1'b1}}));

  // R6
  run_lock_chk: assert property (@(posedge clk) disable iff (porActive)
    inRun |-> (unlockOut == !pllLock));

  // R7
  fall_step_chk: assert property (@(posedge clk) disable iff (porActive)
    inFall |=> (driveDuty == $past(driveDuty) || driveDuty == $past(driveDuty) - DUTY_W'(1)));

  // R7
  prot_zero_chk: assert property (@(posedge clk) disable iff (porActive)
    inProt |-> (driveDuty == '0));

  // R8
  run_exit_chk: assert property (@(posedge clk) disable iff (porActive)
    inRun |=> (inRun || inFall));

endmodule

bind defl_pwr_seq defl_pwr_chk #(.DUTY_W(DUTY_W)) chkInst (
  .clk        (clk),
  .porActive  (porActive),
  .supplyOk   (supplyOk),
  .pllLock    (pllLock),
  .wrSoftstEn (wrSoftstEn),
  .wrBit      (wrBit),
  .supplyEn   (supplyEn),
  .vertEn     (vertEn),
  .horzEn     (horzEn),
  .driveDuty  (driveDuty),
  .unlockOut  (unlockOut),
  .stateCode  (stateCode),
  .rampFlag   (rampFlag)
);

// File: tb/tb_defl_pwr_seq.sv
`timescale 1ns/1ps
module tb_defl_pwr_seq;

  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic porActive = 1'b1;
  logic supplyOk = 1'b1;
  logic pllLock = 1'b0;
  logic wrStdbyEn = 1'b0;
  logic wrSoftstEn = 1'b0;
  logic wrBit = 1'b0;
  logic busAck, supplyEn, vertEn, horzEn, bplusEn, pll1En, pll2En;
  logic [W-1:0] driveDuty;
  logic unlockOut;
  logic [1:0] stateCode;
  logic rampFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  defl_pwr_seq #(.DUTY_W(W), .STEP_DIV(N)) dut (
    .clk(clk), .porActive(porActive), .supplyOk(supplyOk), .pllLock(pllLock),
    .wrStdbyEn(wrStdbyEn), .wrSoftstEn(wrSoftstEn), .wrBit(wrBit),
    .busAck(busAck), .supplyEn(supplyEn), .vertEn(vertEn), .horzEn(horzEn),
    .bplusEn(bplusEn), .pll1En(pll1En), .pll2En(pll2En), .driveDuty(driveDuty),
    .unlockOut(unlockOut), .stateCode(stateCode), .rampFlag(rampFlag)
  );

  localparam logic [2:0] C_OFF = 3'b000, C_STBY = 3'b010, C_PROT = 3'b100,
                         C_RISE = 3'b111, C_RUN = 3'b110, C_FALL = 3'b101;
  localparam logic [6:0] E_OFF = 7'b0000000, E_STBY = 7'b1000000,
                         E_PROT = 7'b1110000, E_ALL = 7'b1111111;

  function automatic logic [2:0] codeNow();
    return {stateCode, rampFlag};
  endfunction

  function automatic logic [6:0] ensNow();
    return {busAck, supplyEn, vertEn, horzEn, bplusEn, pll1En, pll2En};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit selSoftst, input logic val);
    @(negedge clk);
    wrBit = val;
    if (selSoftst) wrSoftstEn = 1'b1; else wrStdbyEn = 1'b1;
    @(negedge clk);
    wrSoftstEn = 1'b0;
    wrStdbyEn = 1'b0;
  endtask

  task automatic waitCode(input logic [2:0] target, output int n);
    n = 0;
    while (codeNow() !== target && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 off code", codeNow(), C_OFF);
    chk("R1 off enables", ensNow(), E_OFF);
    chk("R1 off duty", driveDuty, 0);
    porActive = 1'b0;
    @(negedge clk);
    chk("R1 standby code", codeNow(), C_STBY);
    chk("R1 standby enables", ensNow(), E_STBY);
    chk("R1 standby unlock", unlockOut, 1);
  endtask

  task automatic t_protect();
    wr(1'b0, 1'b0);
    @(negedge clk);
    chk("R2 protection code", codeNow(), C_PROT);
    chk("R2 protection enables", ensNow(), E_PROT);
    chk("R2 protection unlock", unlockOut, 1);
    wr(1'b0, 1'b1);
    @(negedge clk);
    chk("R2 back to standby", codeNow(), C_STBY);
    wr(1'b0, 1'b0);
    @(negedge clk);
    chk("R2 protection again", codeNow(), C_PROT);
  endtask

  task automatic t_gate();
    supplyOk = 1'b0;
    wr(1'b1, 1'b1);
    repeat (6) @(negedge clk);
    chk("R3 gated write ignored", codeNow(), C_PROT);
    chk("R3 duty stays zero", driveDuty, 0);
    supplyOk = 1'b1;
  endtask

  task automatic t_rise();
    int n;
    wr(1'b1, 1'b1);
    @(negedge clk);
    chk("R4 soft-start code", codeNow(), C_RISE);
    chk("R4 soft-start enables", ensNow(), E_ALL);
    chk("R4 duty at entry", driveDuty, 0);
    repeat (N - 1) @(negedge clk);
    chk("R4 duty before first step", driveDuty, 0);
    @(negedge clk);
    chk("R4 duty after first step", driveDuty, 1);
    waitCode(C_RUN, n);
    chk("R5 soft-start length", n + N, 255 * N + 1);
    chk("R5 full duty in operating", driveDuty, 255);
  endtask

  task automatic t_run();
    pllLock = 1'b0;
    #1;
    chk("R6 unlocked", unlockOut, 1);
    pllLock = 1'b1;
    #1;
    chk("R6 locked", unlockOut, 0);
    wr(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 standby write ignored in operating", codeNow(), C_RUN);
  endtask

  task automatic t_fall();
    int n;
    wr(1'b1, 1'b0);
    @(negedge clk);
    chk("R7 soft-down code", codeNow(), C_FALL);
    chk("R7 soft-down start duty", driveDuty, 255);
    waitCode(C_PROT, n);
    chk("R7 soft-down length", n, 255 * N + 1);
    chk("R7 duty zero after soft-down", driveDuty, 0);
    @(negedge clk);
    chk("R8 pending standby applied", codeNow(), C_STBY);
  endtask

  task automatic t_abort();
    int n;
    wr(1'b0, 1'b0);
    @(negedge clk);
    wr(1'b1, 1'b1);
    @(negedge clk);
    chk("R10 soft-start entered", codeNow(), C_RISE);
    repeat (10 * N) @(negedge clk);
    chk("R10 duty before abort", driveDuty, 10);
    wr(1'b1, 1'b0);
    @(negedge clk);
    chk("R10 abort code", codeNow(), C_FALL);
    chk("R10 abort start duty", driveDuty, 10);
    waitCode(C_PROT, n);
    chk("R10 abort descent length", n, 10 * N + 1);
  endtask

  task automatic t_reenter();
    int n;
    wr(1'b1, 1'b1);
    @(negedge clk);
    waitCode(C_RUN, n);
    wr(1'b1, 1'b0);
    @(negedge clk);
    repeat (20) @(negedge clk);
    wr(1'b1, 1'b1);
    @(negedge clk);
    chk("R11 descent continues", codeNow(), C_FALL);
    waitCode(C_PROT, n);
    chk("R11 protection reached", codeNow(), C_PROT);
    chk("R11 duty zero", driveDuty, 0);
    @(negedge clk);
    chk("R11 soft-start restarts", codeNow(), C_RISE);
  endtask

  task automatic t_por();
    repeat (5) @(negedge clk);
    porActive = 1'b1;
    #1;
    chk("R9 immediate off code", codeNow(), C_OFF);
    chk("R9 off enables", ensNow(), E_OFF);
    chk("R9 off duty", driveDuty, 0);
    @(negedge clk);
    porActive = 1'b0;
    @(negedge clk);
    chk("R9 restart in standby", codeNow(), C_STBY);
    repeat (3) @(negedge clk);
    chk("R9 standby bit restored", codeNow(), C_STBY);
  endtask

  initial begin
    t_reset();
    t_protect();
    t_gate();
    t_rise();
    t_run();
    t_fall();
    t_abort();
    t_reenter();
    t_por();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule